// File: doc/BRIEF.md
# Real-Time Clock Interrupt Emulator

This block rebuilds the three interrupt sources of a legacy real-time clock (the once-per-second update interrupt, the time-of-day alarm and the programmable periodic interrupt) on top of one one-shot comparator channel of a free-running event timer. It owns that comparator. Each time the counter reaches it, the block polls: it compares the current time of day against its stored state, advances a decimation counter for the periodic source, and re-arms the comparator one poll interval further on.

The poll interval is the number of counter clocks per base tick multiplied by the base tick rate, divided by the poll rate. The poll rate is 64 Hz unless periodic interrupts are on at a faster programmed rate. The block adds the interval to the previous comparator value and not to the counter, so rounding and service latency do not build up into drift. A poll that raises any source produces a one-cycle interrupt pulse carrying a 16-bit flag word. Calendar keeping and register decoding are done elsewhere. Calendar keeping supplies the time-of-day inputs, and the register decoder drives the enables, the rate and the alarm writes.

Top module: `rtc_irq_emu`

## Requirements
- R1: The poll rate is 64 Hz. When `per_en` is high and the accepted periodic rate is above 64 Hz, the poll rate is that periodic rate. The poll interval is (`base_tick` × TICK_HZ) / poll rate, and because every rate is a power of two this is a right shift.
- R2: An expiry happens when `cmp_armed` is high and `cnt_now` equals `cmp_val`. On an expiry with at least one source enabled, `cmp_val` becomes its previous value plus one poll interval, and the channel stays armed.
- R3: When at least one enable goes high while all three were low in the previous cycle, the next cycle shows `cmp_val` = `cnt_now` + one poll interval and `cmp_armed` = 1.
- R4: On a poll with `upd_en` high, if `cur_sec` differs from the seconds value recorded last, update flag bit 4 is raised and `cur_sec` is recorded. After reset the recorded value is 0.
- R5: With `per_en` high, every poll increments a poll counter. Periodic flag bit 6 is raised on the poll that brings the count to poll rate / periodic rate, and the counter then restarts from 0.
- R6: On a poll with `alm_en` high, alarm flag bit 5 is raised when hour, minute and second all equal the stored alarm time. `alarm_wr` loads that stored time.
- R7: In the cycle after a poll that raises a flag, `irq_pulse` is 1 for one cycle. At the same time `irq_flags` carries bit 7 (IRQ pending) set, bits 15:8 = 8'h01, the raised source bits among 6:4, and bits 3:0 clear. At all other times `irq_flags` is 0.
- R8: A rising edge of `per_en`, and any accepted rate write, clear the poll counter to 0.
- R9: An expiry while all three enables are low gives no pulse, clears `cmp_armed` and leaves `cmp_val` unchanged.
- R10: A rate write is accepted only when `rate_val` is a power of two from 2 to 8192. Any other value is ignored, and the poll interval and poll counter are left unchanged. After reset the rate is 64 Hz.
- R11: After reset `irq_pulse` = 0, `irq_flags` = 0, `cmp_armed` = 0 and `cmp_val` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| rate_wr | input | 1 | Write strobe for the periodic rate |
| rate_val | input | RATE_W (14) | Periodic rate in Hz |
| alarm_wr | input | 1 | Write strobe for the alarm time |
| alarm_hr | input | TIME_W (6) | Alarm hour |
| alarm_min | input | TIME_W (6) | Alarm minute |
| alarm_sec | input | TIME_W (6) | Alarm second |
| cur_hr | input | TIME_W (6) | Current hour |
| cur_min | input | TIME_W (6) | Current minute |
| cur_sec | input | TIME_W (6) | Current second |
| base_tick | input | CNT_W (32) | Counter clocks per base tick |
| cnt_now | input | CNT_W (32) | Free-running main counter value |
| cmp_val | output | CNT_W (32) | Comparator value |
| cmp_armed | output | 1 | Comparator channel armed |
| irq_pulse | output | 1 | Interrupt pulse |
| irq_flags | output | 16 | Interrupt flag word |

## Verification
Some properties are checked on every cycle by the assertions:
- every poll moves the comparator by exactly one interval from its old value;
- the first arm is placed relative to the counter;
- an expiry with nothing enabled disarms the channel silently;
- the flag word keeps its fixed frame;
- the decimation count never passes its threshold.

Other behaviour can only be shown by the bench's scenarios: which flag a given time of day raises, seconds-change detection across repeated and jumping times, the decimation pattern at slow and fast rates, and the poll-rate switch when the periodic rate rises above 64 Hz. The same holds for the counter clearing on a rate rewrite and for invalid rates leaving the interval untouched.

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu #(
  parameter int CNT_W   = 32,
  parameter int RATE_W  = 14,
  parameter int TIME_W  = 6,
  parameter int TICK_HZ = 100,
  parameter int BASE_LG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              alm_en,
  input  logic              per_en,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              alarm_wr,
  input  logic [TIME_W-1:0] alarm_hr,
  input  logic [TIME_W-1:0] alarm_min,
  input  logic [TIME_W-1:0] alarm_sec,
  input  logic [TIME_W-1:0] cur_hr,
  input  logic [TIME_W-1:0] cur_min,
  input  logic [TIME_W-1:0] cur_sec,
  input  logic [CNT_W-1:0]  base_tick,
  input  logic [CNT_W-1:0]  cnt_now,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              cmp_armed,
  output logic              irq_pulse,
  output logic [15:0]       irq_flags
);

  localparam int HZ_W = $clog2(TICK_HZ + 1);
  localparam int PW   = CNT_W + HZ_W;
  localparam int LG_W = $clog2(RATE_W + 1);

  logic [CNT_W-1:0]  cmp_q;
  logic              armed_q;
  logic              irq_q;
  logic [2:0]        src_q;
  logic [LG_W-1:0]   rate_lg;
  logic [RATE_W-1:0] pcount;
  logic [TIME_W-1:0] prev_sec;
  logic [TIME_W-1:0] al_hr, al_min, al_sec;
  logic              prev_any;
  logic              per_q;

  logic              any_en, start, per_rise, rate_ok, expire, hit;
  logic              per_fire, upd_fire, alm_fire;
  logic [LG_W-1:0]   new_lg, poll_lg, diff_lg;
  logic [PW-1:0]     prod;
  logic [CNT_W-1:0]  interval;
  logic [RATE_W-1:0] thr;

  assign any_en   = upd_en | alm_en | per_en;
  assign start    = any_en & ~prev_any;
  assign per_rise = per_en & ~per_q;
  assign rate_ok  = rate_wr && $onehot(rate_val) && !rate_val[0];

  always_comb begin
    new_lg = '0;
    for (int i = 0; i < RATE_W; i++)
      if (rate_val[i]) new_lg = LG_W'(i);
  end

  assign poll_lg  = (per_en && rate_lg > LG_W'(BASE_LG)) ? rate_lg : LG_W'(BASE_LG);
  assign diff_lg  = (poll_lg > rate_lg) ? poll_lg - rate_lg : '0;
  assign thr      = RATE_W'(1) << diff_lg;
  assign prod     = PW'(base_tick) * PW'(TICK_HZ);
  assign interval = CNT_W'(prod >> poll_lg);

  assign expire   = armed_q && (cnt_now == cmp_q);
  assign hit      = expire && any_en && !start;
  assign per_fire = hit && per_en && ((pcount + 1'b1) >= thr);
  assign upd_fire = hit && upd_en && (cur_sec != prev_sec);
  assign alm_fire = hit && alm_en && (cur_hr == al_hr) && (cur_min == al_min)
                    && (cur_sec == al_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_any <= 1'b0;
      per_q    <= 1'b0;
    end else begin
      prev_any <= any_en;
      per_q    <= per_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cmp_q   <= cnt_now + interval;
      armed_q <= 1'b1;
    end else if (expire) begin
      if (any_en) cmp_q <= cmp_q + interval;
      else        armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_lg <= LG_W'(BASE_LG);
    else if (rate_ok) rate_lg <= new_lg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pcount <= '0;
    else if (per_rise || rate_ok) pcount <= '0;
    else if (hit && per_en)     pcount <= per_fire ? '0 : pcount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        prev_sec <= '0;
    else if (upd_fire) prev_sec <= cur_sec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_hr  <= '0;
      al_min <= '0;
      al_sec <= '0;
    end else if (alarm_wr) begin
      al_hr  <= alarm_hr;
      al_min <= alarm_min;
      al_sec <= alarm_sec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      src_q <= '0;
    end else begin
      irq_q <= per_fire | alm_fire | upd_fire;
      src_q <= {per_fire, alm_fire, upd_fire};
    end
  end

  assign cmp_val   = cmp_q;
  assign cmp_armed = armed_q;
  assign irq_pulse = irq_q;
  assign irq_flags = irq_q ? {8'h01, 1'b1, src_q, 4'h0} : 16'h0000;

  a_r2_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cmp_armed && cmp_val == $past(cmp_q + interval)));

  a_r3_first_arm: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cmp_armed && cmp_val == $past(cnt_now + interval)));

  a_r9_idle_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !any_en && !start) |=> (!cmp_armed && !irq_pulse && $stable(cmp_val)));

  a_r7_frame: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_flags[15:7] == 9'h003 && irq_flags[6:4] != 3'b000
                   && irq_flags[3:0] == 4'h0));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pulse |-> (irq_flags == 16'h0000));

  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (per_en && per_q) |-> (pcount < thr));

  a_r10_rate_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_lg >= LG_W'(1) && rate_lg <= LG_W'(RATE_W - 1)));

endmodule

// File: tb/rtc_irq_emu_tb.sv
module rtc_irq_emu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_en = 0, alm_en = 0, per_en = 0, rate_wr = 0, alarm_wr = 0;
  logic [13:0] rate_val = '0;
  logic [5:0]  alarm_hr = 0, alarm_min = 0, alarm_sec = 0;
  logic [5:0]  cur_hr = 0, cur_min = 0, cur_sec = 0;
  logic [31:0] base_tick = 32'd64;
  logic [31:0] cnt_now = 32'd7;
  logic [31:0] cmp_val;
  logic        cmp_armed, irq_pulse;
  logic [15:0] irq_flags;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_cmp;

  localparam logic [31:0] IDLE = 32'h0000_0007;

  // {hr, min, sec, expected flag word}; alarm = 1:2:3, update and alarm on
  localparam logic [33:0] VEC [8] = '{
    {6'd1, 6'd2, 6'd0, 16'h0000},
    {6'd1, 6'd2, 6'd1, 16'h0190},
    {6'd1, 6'd2, 6'd1, 16'h0000},
    {6'd1, 6'd2, 6'd3, 16'h01B0},
    {6'd1, 6'd2, 6'd3, 16'h01A0},
    {6'd1, 6'd3, 6'd3, 16'h0000},
    {6'd2, 6'd2, 6'd4, 16'h0190},
    {6'd1, 6'd2, 6'd3, 16'h01B0}
  };

  always #2 clk = ~clk;

  rtc_irq_emu dut_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en),
    .rate_wr(rate_wr), .rate_val(rate_val), .alarm_wr(alarm_wr),
    .alarm_hr(alarm_hr), .alarm_min(alarm_min), .alarm_sec(alarm_sec),
    .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
    .base_tick(base_tick), .cnt_now(cnt_now), .cmp_val(cmp_val),
    .cmp_armed(cmp_armed), .irq_pulse(irq_pulse), .irq_flags(irq_flags)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poll(input logic [5:0] h, input logic [5:0] m, input logic [5:0] s,
                      input logic [15:0] flags, input logic [31:0] step, input string req);
    @(negedge clk);
    cur_hr = h; cur_min = m; cur_sec = s;
    cnt_now = exp_cmp;
    @(posedge clk); #1;
    check(irq_pulse == (flags != 0), req, {31'd0, irq_pulse}, {31'd0, flags != 0});
    check(irq_flags == flags, req, {16'd0, irq_flags}, {16'd0, flags});
    exp_cmp = exp_cmp + step;
    check(cmp_val == exp_cmp && cmp_armed, {req, " R2 step"}, cmp_val, exp_cmp);
    @(negedge clk);
    cnt_now = IDLE;
  endtask

  task automatic write_rate(input logic [13:0] r);
    @(negedge clk);
    rate_val = r; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R11 reset state
    check(!irq_pulse && irq_flags == 0, "R11", {16'd0, irq_flags}, 32'd0);
    check(!cmp_armed && cmp_val == 0, "R11", cmp_val, 32'd0);

    @(negedge clk);
    alarm_hr = 6'd1; alarm_min = 6'd2; alarm_sec = 6'd3; alarm_wr = 1'b1;
    @(negedge clk);
    alarm_wr = 1'b0;
    cnt_now = 32'd1000; upd_en = 1'b1; alm_en = 1'b1;
    @(posedge clk); #1;
    // R3 initial arm at counter + 6400/64 (R1 default 64 Hz)
    exp_cmp = 32'd1100;
    check(cmp_armed && cmp_val == exp_cmp, "R3 R1", cmp_val, exp_cmp);
    @(negedge clk) cnt_now = IDLE;

    // R4 R6 R7 table walk
    for (int i = 0; i < 8; i++)
      poll(VEC[i][33:28], VEC[i][27:22], VEC[i][21:16], VEC[i][15:0], 32'd100, "R4 R6 R7");

    // R9 all disabled: expiry is silent and disarms
    @(negedge clk);
    upd_en = 1'b0; alm_en = 1'b0;
    @(negedge clk) cnt_now = exp_cmp;
    @(posedge clk); #1;
    check(!irq_pulse && !cmp_armed, "R9", {31'd0, cmp_armed}, 32'd0);
    check(cmp_val == exp_cmp, "R9", cmp_val, exp_cmp);
    @(negedge clk) cnt_now = IDLE;

    // R5 periodic at 16 Hz: fires every 4th poll
    write_rate(14'd16);
    @(negedge clk);
    cnt_now = 32'd2000; per_en = 1'b1;
    @(posedge clk); #1;
    exp_cmp = 32'd2100;
    check(cmp_val == exp_cmp, "R3", cmp_val, exp_cmp);
    @(negedge clk) cnt_now = IDLE;
    poll(1, 2, 3, 16'h0000, 32'd100, "R5");
    poll(1, 2, 3, 16'h0000, 32'd100, "R5");
    poll(1, 2, 3, 16'h0000, 32'd100, "R5");
    poll(1, 2, 3, 16'h01C0, 32'd100, "R5");

    // R8 rewrite clears the count
    poll(1, 2, 3, 16'h0000, 32'd100, "R8");
    poll(1, 2, 3, 16'h0000, 32'd100, "R8");
    write_rate(14'd16);
    poll(1, 2, 3, 16'h0000, 32'd100, "R8");
    poll(1, 2, 3, 16'h0000, 32'd100, "R8");
    poll(1, 2, 3, 16'h0000, 32'd100, "R8");
    poll(1, 2, 3, 16'h01C0, 32'd100, "R8");

    // R10 invalid rates ignored: count and interval unchanged
    poll(1, 2, 3, 16'h0000, 32'd100, "R10");
    write_rate(14'd384);
    write_rate(14'd1);
    poll(1, 2, 3, 16'h0000, 32'd100, "R10");
    poll(1, 2, 3, 16'h0000, 32'd100, "R10");
    poll(1, 2, 3, 16'h01C0, 32'd100, "R10");

    // R1 rate 256 raises the poll rate: interval 25, every poll fires
    write_rate(14'd256);
    poll(1, 2, 3, 16'h01C0, 32'd25, "R1 R5");
    poll(1, 2, 3, 16'h01C0, 32'd25, "R1 R5");

    // R1 periodic off: back to 64 Hz polling
    @(negedge clk) upd_en = 1'b1;
    @(negedge clk) per_en = 1'b0;
    poll(1, 2, 3, 16'h0000, 32'd100, "R1");
    poll(1, 2, 5, 16'h0190, 32'd100, "R1 R4");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule